// File: doc/BRIEF.md
# Random Transient Pulse Fault Injector

This block lets a built-in self-test plant synthetic single-event transients on a short list of sensitive internal nodes. It sits on the functional path of those nodes. While it is idle, every node passes through untouched. When software-independent test logic raises a trigger, the block draws a pseudo-random pulse width and a pseudo-random arrival offset from a maximal-length Galois LFSR. It then forces one selected node to a fixed level for exactly that many ticks, starting that many ticks after the trigger edge. One tick stands for one delay element, so a sweep of triggers covers a spread of widths and arrival times relative to the capturing clock edge.

The pulse is shaped the way a latch-and-delay-line pulse generator works. An internal set/reset latch goes high when the offset has elapsed, a tapped delay line produces a late copy of it, and the XOR of the two is the pulse. Each node has a three-way selector: pass-through, forced low or forced high. Only one pulse is in flight at a time. A trigger that arrives while a pulse is pending or active is dropped and counted.

There is no data stream here, so there is no valid/ready handshake and no back-pressure. A trigger is never held off. `busy` is advisory, and a trigger that meets a busy block is simply lost and tallied.

Top module: `transient_injector`

## Requirements
- R1: After reset, `node_out` equals `node_in`, `busy` is 0, `drop_count` is 0, and the generator state is `DEFAULT_SEED`.
- R2: `inj_mode` encodes 2'b01 as forced low and 2'b10 as forced high. 2'b00 and 2'b11 mean pass-through. A trigger with a pass-through mode, or with `inj_en` low, starts nothing, does not advance the generator and is not counted.
- R3: During a pulse, only the node whose index equals the captured `target_idx` differs from `node_in`. An index of `NODES` or above disturbs no node, but the pulse still runs its full busy time.
- R4: A trigger is accepted if it is sampled at clock edge e0 while the block is idle, with `inj_en` high and a forcing mode. The forced level is then visible in the w cycles that follow edges e0+ofs to e0+ofs+w-1. `busy` is high for the ofs+w+1 cycles that follow edges e0 to e0+ofs+w.
- R5: The offset is ofs = `BASE_OFS` + S[WIDTH_BITS+OFS_BITS-1:WIDTH_BITS], where S is the generator state at acceptance.
- R6: The width is w = S[WIDTH_BITS-1:0], except that a zero field gives w = 1. A zero width is never issued.
- R7: The generator shifts right once per accepted trigger. When the bit shifted out is 1, the new state is XORed with the mask. For an 8-bit state the mask is 8'hB8, giving period 255. The state is never zero.
- R8: `seed_load` replaces the state with `seed`, and a zero seed is replaced by `DEFAULT_SEED`.
- R9: A trigger sampled with `inj_en` high while `busy` is high is ignored and adds 1 to `drop_count`. The count saturates at its all-ones value.
- R10: Target and polarity are captured at acceptance. Changes to `target_idx` or `inj_mode` during the pulse do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one tick |
| rst_n | input | 1 | Active-low synchronous reset |
| node_in | input | NODES | Functional values of the target nodes |
| node_out | output | NODES | Node values after injection |
| inj_en | input | 1 | Enables trigger acceptance and drop counting |
| inj_mode | input | 2 | Pass (00/11), forced low (01), forced high (10) |
| target_idx | input | IDX_W | Index of the node to disturb |
| trig | input | 1 | Request a pulse |
| seed_load | input | 1 | Load `seed` into the generator |
| seed | input | LFSR_W | Generator seed |
| busy | output | 1 | A pulse is pending or active |
| drop_count | output | CNT_W | Saturating count of triggers lost to a busy block |

## Verification
The bench builds the block with NODES=12, which leaves indices 12 to 15 on a 4-bit `target_idx`, so the out-of-range target case can actually be driven. LFSR_W=8 with 3-bit width and offset fields makes zero-width draws frequent, and a chosen seed forces one at will; the bench model follows the 8'hB8 sequence pulse by pulse. CNT_W=6 puts drop-count saturation at 63, within a few dozen dropped triggers.

// File: rtl/tpi_pkg.sv
package tpi_pkg;

  typedef enum logic [1:0] {
    INJ_PASS  = 2'b00,
    INJ_LOW   = 2'b01,
    INJ_HIGH  = 2'b10,
    INJ_PASS2 = 2'b11
  } inj_mode_e;

  // Right-shifting Galois feedback masks giving maximal period, widths 4..16.
  function automatic logic [31:0] galois_mask(input int unsigned w);
    case (w)
      4:       return 32'h0000_000C;
      5:       return 32'h0000_0014;
      6:       return 32'h0000_0030;
      7:       return 32'h0000_0060;
      8:       return 32'h0000_00B8;
      9:       return 32'h0000_0110;
      10:      return 32'h0000_0240;
      11:      return 32'h0000_0500;
      12:      return 32'h0000_0E08;
      13:      return 32'h0000_1C80;
      14:      return 32'h0000_3802;
      15:      return 32'h0000_6000;
      default: return 32'h0000_B400;
    endcase
  endfunction

endpackage

// File: rtl/tpi_lfsr.sv
module tpi_lfsr #(
  parameter int unsigned W            = 16,
  parameter int unsigned DEFAULT_SEED = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         step,
  output logic [W-1:0] state
);
  localparam logic [W-1:0] MASK = W'(tpi_pkg::galois_mask(W));
  localparam logic [W-1:0] SAFE = (W'(DEFAULT_SEED) == '0) ? W'(1) : W'(DEFAULT_SEED);

  logic [W-1:0] shifted;

  always_comb begin
    shifted = state >> 1;
    if (state[0]) shifted = shifted ^ MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SAFE;
    end else if (load) begin
      state <= (seed == '0) ? SAFE : seed;
    end else if (step) begin
      state <= shifted;
    end
  end
endmodule

// File: rtl/tpi_pulse_former.sv
module tpi_pulse_former #(
  parameter int unsigned WW       = 3,
  parameter int unsigned OW       = 3,
  parameter int unsigned BASE_OFS = 4,
  parameter int unsigned IDX_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WW-1:0]    field_w,
  input  logic [OW-1:0]    field_o,
  input  logic [IDX_W-1:0] tgt_in,
  input  logic             low_in,
  output logic             busy,
  output logic             pulse,
  output logic [IDX_W-1:0] tgt_q,
  output logic             low_q
);
  localparam int unsigned MAXW = (1 << WW) - 1;
  localparam int unsigned OMAX = BASE_OFS + (1 << OW) - 1;
  localparam int unsigned DCW  = $clog2(OMAX + 1);

  logic           armed;
  logic [DCW-1:0] dcnt;
  logic [WW-1:0]  wq;
  logic           latch_q;
  logic [MAXW:1]  dline;
  logic           late_q;
  logic [WW-1:0]  w_eff;

  assign w_eff = (field_w == '0) ? WW'(1) : field_w;

  // Tap of the delay line selected by the captured width.
  always_comb begin
    late_q = 1'b0;
    for (int k = 1; k <= int'(MAXW); k++) begin
      if (wq == WW'(k)) late_q = dline[k];
    end
  end

  // Offset countdown, then set the latch.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      dcnt  <= '0;
      wq    <= WW'(1);
      tgt_q <= '0;
      low_q <= 1'b0;
    end else if (start) begin
      armed <= 1'b1;
      dcnt  <= DCW'(BASE_OFS) + DCW'(field_o);
      wq    <= w_eff;
      tgt_q <= tgt_in;
      low_q <= low_in;
    end else if (armed) begin
      if (dcnt == DCW'(1)) armed <= 1'b0;
      else                 dcnt  <= dcnt - DCW'(1);
    end
  end

  // Set/reset latch and its delayed copy.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
      dline   <= '0;
    end else if (latch_q && late_q) begin
      latch_q <= 1'b0;
      dline   <= '0;
    end else begin
      if (armed && dcnt == DCW'(1)) latch_q <= 1'b1;
      dline <= {dline[MAXW-1:1], latch_q};
    end
  end

  assign pulse = latch_q ^ late_q;
  assign busy  = armed | latch_q | (|dline);
endmodule

// File: rtl/tpi_node_mux.sv
module tpi_node_mux #(
  parameter int unsigned NODES = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic [NODES-1:0] node_in,
  input  logic             pulse,
  input  logic [IDX_W-1:0] tgt,
  input  logic             low,
  output logic [NODES-1:0] node_out
);
  for (genvar g = 0; g < NODES; g++) begin : g_node
    logic hit;
    assign hit         = pulse && (tgt == IDX_W'(g));
    assign node_out[g] = hit ? ~low : node_in[g];
  end
endmodule

// File: rtl/transient_injector.sv
module transient_injector #(
  parameter int unsigned NODES        = 16,
  parameter int unsigned LFSR_W       = 16,
  parameter int unsigned WIDTH_BITS   = 3,
  parameter int unsigned OFS_BITS     = 3,
  parameter int unsigned BASE_OFS     = 4,
  parameter int unsigned CNT_W        = 8,
  parameter int unsigned DEFAULT_SEED = 1,
  parameter int unsigned IDX_W        = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NODES-1:0]  node_in,
  output logic [NODES-1:0]  node_out,
  input  logic              inj_en,
  input  logic [1:0]        inj_mode,
  input  logic [IDX_W-1:0]  target_idx,
  input  logic              trig,
  input  logic              seed_load,
  input  logic [LFSR_W-1:0] seed,
  output logic              busy,
  output logic [CNT_W-1:0]  drop_count
);
  import tpi_pkg::*;

  logic                  forcing;
  logic                  accept;
  logic                  drop_hit;
  logic [LFSR_W-1:0]     lfsr_q;
  logic                  pulse_w;
  logic [IDX_W-1:0]      tgt_q;
  logic                  low_q;

  assign forcing  = (inj_mode == INJ_LOW) || (inj_mode == INJ_HIGH);
  assign accept   = trig && inj_en && !busy && forcing;
  assign drop_hit = trig && inj_en && busy;

  tpi_lfsr #(
    .W            (LFSR_W),
    .DEFAULT_SEED (DEFAULT_SEED)
  ) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (seed_load),
    .seed  (seed),
    .step  (accept),
    .state (lfsr_q)
  );

  tpi_pulse_former #(
    .WW       (WIDTH_BITS),
    .OW       (OFS_BITS),
    .BASE_OFS (BASE_OFS),
    .IDX_W    (IDX_W)
  ) u_former (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .field_w (lfsr_q[WIDTH_BITS-1:0]),
    .field_o (lfsr_q[WIDTH_BITS+OFS_BITS-1:WIDTH_BITS]),
    .tgt_in  (target_idx),
    .low_in  (inj_mode == INJ_LOW),
    .busy    (busy),
    .pulse   (pulse_w),
    .tgt_q   (tgt_q),
    .low_q   (low_q)
  );

  tpi_node_mux #(
    .NODES (NODES),
    .IDX_W (IDX_W)
  ) u_mux (
    .node_in  (node_in),
    .pulse    (pulse_w),
    .tgt      (tgt_q),
    .low      (low_q),
    .node_out (node_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drop_count <= '0;
    end else if (drop_hit && (drop_count != '1)) begin
      drop_count <= drop_count + CNT_W'(1);
    end
  end
endmodule

// File: rtl/transient_injector_chk.sv
module transient_injector_chk #(
  parameter int unsigned NODES  = 16,
  parameter int unsigned LFSR_W = 16,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NODES-1:0]  node_in,
  input logic [NODES-1:0]  node_out,
  input logic              inj_en,
  input logic [1:0]        inj_mode,
  input logic              trig,
  input logic              busy,
  input logic [CNT_W-1:0]  drop_count,
  input logic [LFSR_W-1:0] lfsr_state
);
  logic fmode;
  assign fmode = (inj_mode == 2'b01) || (inj_mode == 2'b10);

  // R3: at most one node is disturbed at any time
  a_r3_single_node: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(node_out ^ node_in) <= 1);

  // R4: an idle block leaves every node untouched
  a_r4_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (node_out == node_in));

  // R4: an accepted trigger makes the block busy
  a_r4_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && trig && inj_en && fmode) |=> busy);

  // R2: pass-through mode or a disabled trigger starts nothing
  a_r2_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && trig && (!inj_en || !fmode)) |=> !busy);

  // R9: a trigger hitting a busy block bumps the counter
  a_r9_drop_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && trig && inj_en && (drop_count != '1)) |=> (drop_count == $past(drop_count) + CNT_W'(1)));

  // R9: the counter moves for nothing else
  a_r9_drop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && trig && inj_en) |=> $stable(drop_count));

  // R7: generator state never collapses to zero
  a_r7_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_state != '0);
endmodule

bind transient_injector transient_injector_chk #(
  .NODES  (NODES),
  .LFSR_W (LFSR_W),
  .CNT_W  (CNT_W),
  .IDX_W  (IDX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .node_in    (node_in),
  .node_out   (node_out),
  .inj_en     (inj_en),
  .inj_mode   (inj_mode),
  .trig       (trig),
  .busy       (busy),
  .drop_count (drop_count),
  .lfsr_state (lfsr_q)
);

// File: tb/transient_injector_test.sv
module transient_injector_test;
  localparam int NODES = 12;
  localparam int LW    = 8;
  localparam int CW    = 6;
  localparam int IW    = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NODES-1:0] node_in = '0;
  logic [NODES-1:0] node_out;
  logic             inj_en = 1'b0;
  logic [1:0]       inj_mode = 2'b00;
  logic [IW-1:0]    target_idx = '0;
  logic             trig = 1'b0;
  logic             seed_load = 1'b0;
  logic [LW-1:0]    seed = '0;
  logic             busy;
  logic [CW-1:0]    drop_count;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [LW-1:0] ms;
  int exp_drop = 0;
  bit done = 0;

  typedef struct {
    int    start;
    int    width;
    int    node;
    logic  level;
    string tag;
  } pulse_t;
  pulse_t sb[$];

  transient_injector #(
    .NODES(NODES), .LFSR_W(LW), .WIDTH_BITS(3), .OFS_BITS(3),
    .BASE_OFS(4), .CNT_W(CW), .DEFAULT_SEED(1)
  ) uut (
    .clk(clk), .rst_n(rst_n), .node_in(node_in), .node_out(node_out),
    .inj_en(inj_en), .inj_mode(inj_mode), .target_idx(target_idx),
    .trig(trig), .seed_load(seed_load), .seed(seed),
    .busy(busy), .drop_count(drop_count)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [LW-1:0] lstep(logic [LW-1:0] s);
    return s[0] ? ((s >> 1) ^ 8'hB8) : (s >> 1);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Monitor: measure each disturbance and compare with the scoreboard.
  int  m_st, m_len, m_node;
  bit  m_in = 0;
  logic m_lvl;
  always @(negedge clk) begin
    if (rst_n) begin
      logic [NODES-1:0] d;
      d = node_out ^ node_in;
      if (d != '0) begin
        if ($countones(d) != 1)
          check(0, "R3", "nodes disturbed at once", $countones(d), 1);
        if (!m_in) begin
          m_in = 1; m_st = cyc; m_len = 1;
          for (int i = 0; i < NODES; i++) if (d[i]) m_node = i;
          m_lvl = node_out[m_node];
        end else m_len++;
      end else if (m_in) begin
        m_in = 0;
        if (sb.size() == 0) begin
          check(0, "R3", "unexpected pulse on node", m_node, -1);
        end else begin
          pulse_t e;
          e = sb.pop_front();
          checks++;
          if (m_st != e.start || m_len != e.width || m_node != e.node || m_lvl != e.level) begin
            fails++;
            $display("FAIL %s pulse: actual start %0d width %0d node %0d level %0d expected start %0d width %0d node %0d level %0d",
                     e.tag, m_st, m_len, m_node, m_lvl, e.start, e.width, e.node, e.level);
          end
        end
      end
    end
  end

  task automatic load_seed(logic [LW-1:0] v);
    @(posedge clk); #1;
    seed = v; seed_load = 1'b1;
    @(posedge clk); #1;
    seed_load = 1'b0;
    ms = (v == '0) ? 8'h01 : v;
  endtask

  // Driver: fire one pulse, push its expected shape, wait for idle.
  task automatic fire(int tgt, logic [1:0] mode, int ndrop, bit change_mid, string tag);
    int c0, w, ofs;
    @(posedge clk); #1;
    node_in = (mode == 2'b01) ? '1 : '0;
    target_idx = IW'(tgt); inj_mode = mode; inj_en = 1'b1; trig = 1'b1;
    @(posedge clk); #1;
    c0  = cyc;
    w   = (ms[2:0] == 3'd0) ? 1 : int'(ms[2:0]);
    ofs = 4 + int'(ms[5:3]);
    ms  = lstep(ms);
    if (tgt < NODES) sb.push_back('{c0 + ofs, w, tgt, (mode == 2'b10), tag});
    if (ndrop > 0) begin
      repeat (ndrop) @(posedge clk);
      #1;
      exp_drop = (exp_drop + ndrop > 63) ? 63 : exp_drop + ndrop;
    end
    trig = 1'b0;
    if (change_mid) begin
      target_idx = IW'(tgt ^ 1);
      inj_mode = (mode == 2'b01) ? 2'b10 : 2'b01;
    end
    do @(negedge clk); while (busy);
    check(cyc - c0 == ofs + w + 1, "R4", "busy length", cyc - c0, ofs + w + 1);
    check(int'(drop_count) == exp_drop, "R9", "drop count", int'(drop_count), exp_drop);
    inj_mode = 2'b00;
  endtask

  task automatic try_idle(logic [1:0] mode, logic en);
    @(posedge clk); #1;
    inj_mode = mode; inj_en = en; trig = 1'b1;
    @(posedge clk); #1;
    trig = 1'b0;
    @(negedge clk);
    check(busy == 1'b0, "R2", "busy after ignored trigger", int'(busy), 0);
    check(int'(drop_count) == exp_drop, "R2", "drop count after ignored trigger", int'(drop_count), exp_drop);
  endtask

  initial begin : main
    ms = 8'h01;
    node_in = 12'hA5C;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(node_out == node_in, "R1", "node_out under reset", int'(node_out), int'(node_in));
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(node_out == node_in, "R1", "node_out after reset", int'(node_out), int'(node_in));
    check(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    check(drop_count == '0, "R1", "drop_count after reset", int'(drop_count), 0);

    // R7: sequence from the default reset state
    for (int i = 0; i < 6; i++) fire(i * 2, (i % 2) ? 2'b10 : 2'b01, 0, 0, "R7");
    // R8, R5: loaded seed
    load_seed(8'h5A);
    for (int i = 0; i < 20; i++) fire(i % NODES, (i % 3 == 0) ? 2'b10 : 2'b01, 0, 0, "R5");
    // R8: zero seed falls back to default
    load_seed(8'h00);
    for (int i = 0; i < 4; i++) fire(11 - i, 2'b10, 0, 0, "R8");
    // R6: width field zero gives one tick
    load_seed(8'h40);
    fire(3, 2'b01, 0, 0, "R6");
    fire(4, 2'b10, 0, 0, "R6");
    // R2: pass modes and disabled triggers are ignored
    try_idle(2'b00, 1'b1);
    try_idle(2'b11, 1'b1);
    try_idle(2'b01, 1'b0);
    fire(7, 2'b01, 0, 0, "R2");
    // R3: out-of-range index and top index
    fire(13, 2'b10, 0, 0, "R3");
    fire(11, 2'b01, 0, 0, "R3");
    // R10: inputs changed mid-pulse
    fire(5, 2'b01, 0, 1, "R10");
    fire(8, 2'b10, 0, 1, "R10");
    // R9: drops and saturation
    fire(2, 2'b01, 3, 0, "R9");
    for (int i = 0; i < 15; i++) fire(i % NODES, 2'b10, 5, 0, "R9");
    check(int'(drop_count) == 63, "R9", "saturated drop count", int'(drop_count), 63);
    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R4", "pulses never seen", sb.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule